// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block keeps the two programmable thresholds that a FIFO's flag logic compares against. One is the almost-empty distance and the other is the almost-full distance. Each threshold is stored as a low part and a high part. After reset the thresholds hold default values from parameters. Software or a board controller can then change them in one of two ways: as four ordered words over the data bus, or as one long serial stream shifted in a bit at a time. The way is chosen once, at reset. The stored values can always be read back over the bus in the same four-word order. Both thresholds drive the flag logic continuously.

An access-select input decides what the read and write strobes act on. With access-select low, the strobes reach the threshold registers. With access-select high, they go straight through to the FIFO memory as plain enables. All strobes and the select are active low. Everything is synchronous to one clock, and the serial path shifts on clock edges where its enable is low. Offset reads must be spaced: a read request in the cycle right after another read request is refused and reported.

Top module: `flofs_loader`

## Requirements
- R1: Reset is asynchronous and active low. During reset and on release, `empty_ofs` equals DEF_EMPTY and `full_ofs` equals DEF_FULL, `bus_out` is 0, and `bus_out_vld` and `rd_err` are 0. The write, read and serial pointers all point at the first position.
- R2: With `acc_sel_n` high, `mem_wr_en` equals the inverse of `wr_n` and `mem_rd_en` equals the inverse of `rd_n`, in the same cycle and without a register. With `acc_sel_n` low, both are 0. Memory cycles leave the thresholds unchanged.
- R3: In parallel mode, each clock edge with `acc_sel_n` and `wr_n` low stores one word. The order is: empty low part (bus bits LO_W-1:0), empty high part (bus bits HI_W-1:0), full low part, full high part. After the fourth word the order starts again at the empty low part.
- R4: In serial mode, parallel write requests leave both thresholds unchanged.
- R5: A read request is an edge with `acc_sel_n` and `rd_n` low. When accepted, it returns the next part in the same four-step order on `bus_out`, zero-extended, in the following cycle. `bus_out_vld` is high for that one cycle. `bus_out` keeps its value otherwise. A read returns the contents from before any write on the same edge.
- R6: Readback works the same way in serial mode.
- R7: A read request on the edge right after an edge that carried a read request is refused. No data is returned and the read pointer does not move. `rd_err` is high for the following cycle.
- R8: In serial mode, each edge with `acc_sel_n` and `shift_n` low stores `shift_din` into bit k of the combined vector {full, empty}. Here k counts from 0 up to 2*(LO_W+HI_W)-1 and then wraps to 0. Bit 0 is the empty low part's LSB, and the last bit is the full high part's MSB.
- R9: In parallel mode, serial shift requests leave both thresholds unchanged.
- R10: The mode is `ser_mode_cfg` (1 = serial) as sampled during reset. Changing it after reset has no effect.
- R11: Cycles with no offset write and no shift leave both thresholds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous master reset, active low |
| ser_mode_cfg | input | 1 | Programming mode, sampled during reset (1 = serial) |
| acc_sel_n | input | 1 | Low: strobes act on the thresholds; high: strobes act on the memory |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| shift_n | input | 1 | Serial shift enable, active low |
| bus_in | input | BUS_W | Parallel write data |
| shift_din | input | 1 | Serial data bit |
| mem_wr_en | output | 1 | Memory write enable |
| mem_rd_en | output | 1 | Memory read enable |
| bus_out | output | BUS_W | Readback data |
| bus_out_vld | output | 1 | One-cycle strobe marking readback data |
| rd_err | output | 1 | One-cycle strobe for a refused read |
| empty_ofs | output | LO_W+HI_W | Almost-empty threshold |
| full_ofs | output | LO_W+HI_W | Almost-full threshold |

## Verification
The bench builds the block with a 16-bit low part, a 3-bit high part and an 18-bit bus. This puts the zero-extension of readback data within reach, along with bus bits that must be ignored on high-part writes. The defaults are distinct non-zero thresholds, so an early overwrite or a wrong reset value shows up. The 38-bit serial stream is shifted in once and then partly again, which exercises the pointer wrap. The bench resets in both modes and changes the mode input between resets.

// File: rtl/flofs_pkg.sv
package flofs_pkg;

   // Four-step order shared by the parallel write and readback pointers.
   // Bit 1 selects the threshold (0 = empty, 1 = full); bit 0 selects the high part.
   typedef enum logic [1:0] {
      PART_E_LO = 2'd0,
      PART_E_HI = 2'd1,
      PART_F_LO = 2'd2,
      PART_F_HI = 2'd3
   } part_e;

   // Decoded operation for one clock edge.
   typedef struct packed {
      logic reg_wr;
      logic reg_rd;
      logic shift;
      logic mem_wr;
      logic mem_rd;
   } ctl_s;

   function automatic part_e part_next(part_e p);
      return part_e'(p + 2'd1);
   endfunction

endpackage

// File: rtl/flofs_decode.sv
module flofs_decode
   import flofs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ser_mode_cfg,
   input  logic acc_sel_n,
   input  logic wr_n,
   input  logic rd_n,
   input  logic shift_n,
   output ctl_s ctl
);

   logic ser_mode_q;

   // The mode follows the config pin only while reset is held.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ser_mode_q <= ser_mode_cfg;
      else        ser_mode_q <= ser_mode_q;
   end

   always_comb begin
      ctl.reg_wr = !acc_sel_n && !wr_n && !ser_mode_q;
      ctl.reg_rd = !acc_sel_n && !rd_n;
      ctl.shift  = !acc_sel_n && !shift_n && ser_mode_q;
      ctl.mem_wr = acc_sel_n && !wr_n;
      ctl.mem_rd = acc_sel_n && !rd_n;
   end

endmodule

// File: rtl/flofs_store.sv
module flofs_store
   import flofs_pkg::*;
#(
   parameter int LO_W  = 16,
   parameter int HI_W  = 3,
   parameter int BUS_W = 16,
   parameter logic [LO_W+HI_W-1:0] DEF_EMPTY = '0,
   parameter logic [LO_W+HI_W-1:0] DEF_FULL  = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_stb,
   input  logic                         shift_stb,
   input  logic [BUS_W-1:0]             bus_in,
   input  logic                         shift_din,
   output logic [2*(LO_W+HI_W)-1:0]     ofs_q
);

   localparam int OFS_W    = LO_W + HI_W;
   localparam int SER_BITS = 2 * OFS_W;
   localparam int SP_W     = $clog2(SER_BITS);
   localparam logic [SER_BITS-1:0] DEF_ALL = {DEF_FULL, DEF_EMPTY};

   part_e           wr_ptr;
   logic [SP_W-1:0] ser_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= PART_E_LO;
         ser_ptr <= '0;
      end else begin
         if (wr_stb) wr_ptr <= part_next(wr_ptr);
         if (shift_stb)
            ser_ptr <= (ser_ptr == SP_W'(SER_BITS - 1)) ? '0 : ser_ptr + 1'b1;
      end
   end

   // One register per threshold; index 0 is empty, index 1 is full.
   for (genvar r = 0; r < 2; r++) begin : g_reg
      logic [OFS_W-1:0] reg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            reg_q <= DEF_ALL[r*OFS_W +: OFS_W];
         end else begin
            if (wr_stb && wr_ptr == part_e'(2*r))
               reg_q[LO_W-1:0] <= bus_in[LO_W-1:0];
            if (wr_stb && wr_ptr == part_e'(2*r + 1))
               reg_q[OFS_W-1:LO_W] <= bus_in[HI_W-1:0];
            for (int b = 0; b < OFS_W; b++) begin
               if (shift_stb && ser_ptr == SP_W'(r*OFS_W + b))
                  reg_q[b] <= shift_din;
            end
         end
      end

      assign ofs_q[r*OFS_W +: OFS_W] = reg_q;
   end

endmodule

// File: rtl/flofs_readback.sv
module flofs_readback
   import flofs_pkg::*;
#(
   parameter int LO_W  = 16,
   parameter int HI_W  = 3,
   parameter int BUS_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_req,
   input  logic [2*(LO_W+HI_W)-1:0]   ofs_q,
   output logic [BUS_W-1:0]           bus_out,
   output logic                       bus_out_vld,
   output logic                       rd_err
);

   localparam int OFS_W = LO_W + HI_W;

   part_e              rd_ptr;
   logic               prev_req;
   logic [OFS_W-1:0]   sel_word;
   logic [BUS_W-1:0]   sel_part;
   logic               rd_ok;

   always_comb begin
      sel_word = rd_ptr[1] ? ofs_q[2*OFS_W-1:OFS_W] : ofs_q[OFS_W-1:0];
      sel_part = rd_ptr[0] ? BUS_W'(sel_word[OFS_W-1:LO_W])
                           : BUS_W'(sel_word[LO_W-1:0]);
      rd_ok    = rd_req && !prev_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr      <= PART_E_LO;
         prev_req    <= 1'b0;
         bus_out     <= '0;
         bus_out_vld <= 1'b0;
         rd_err      <= 1'b0;
      end else begin
         prev_req    <= rd_req;
         bus_out_vld <= rd_ok;
         rd_err      <= rd_req && prev_req;
         if (rd_ok) begin
            bus_out <= sel_part;
            rd_ptr  <= part_next(rd_ptr);
         end
      end
   end

endmodule

// File: rtl/flofs_loader.sv
module flofs_loader
   import flofs_pkg::*;
#(
   parameter int LO_W  = 16,
   parameter int HI_W  = 3,
   parameter int BUS_W = 16,
   parameter logic [LO_W+HI_W-1:0] DEF_EMPTY = 19'h0007F,
   parameter logic [LO_W+HI_W-1:0] DEF_FULL  = 19'h0007F
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_mode_cfg,
   input  logic                     acc_sel_n,
   input  logic                     wr_n,
   input  logic                     rd_n,
   input  logic                     shift_n,
   input  logic [BUS_W-1:0]         bus_in,
   input  logic                     shift_din,
   output logic                     mem_wr_en,
   output logic                     mem_rd_en,
   output logic [BUS_W-1:0]         bus_out,
   output logic                     bus_out_vld,
   output logic                     rd_err,
   output logic [LO_W+HI_W-1:0]     empty_ofs,
   output logic [LO_W+HI_W-1:0]     full_ofs
);

   localparam int OFS_W = LO_W + HI_W;

   if (LO_W < 1 || HI_W < 1) begin : g_bad_part
      $error("flofs_loader: both parts need at least one bit");
   end
   if (LO_W > BUS_W || HI_W > BUS_W) begin : g_bad_bus
      $error("flofs_loader: bus narrower than a threshold part");
   end

   ctl_s               ctl;
   logic [2*OFS_W-1:0] ofs_q;

   flofs_decode u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .ser_mode_cfg (ser_mode_cfg),
      .acc_sel_n    (acc_sel_n),
      .wr_n         (wr_n),
      .rd_n         (rd_n),
      .shift_n      (shift_n),
      .ctl          (ctl)
   );

   flofs_store #(
      .LO_W(LO_W), .HI_W(HI_W), .BUS_W(BUS_W),
      .DEF_EMPTY(DEF_EMPTY), .DEF_FULL(DEF_FULL)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (ctl.reg_wr),
      .shift_stb (ctl.shift),
      .bus_in    (bus_in),
      .shift_din (shift_din),
      .ofs_q     (ofs_q)
   );

   flofs_readback #(
      .LO_W(LO_W), .HI_W(HI_W), .BUS_W(BUS_W)
   ) u_rdb (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_req      (ctl.reg_rd),
      .ofs_q       (ofs_q),
      .bus_out     (bus_out),
      .bus_out_vld (bus_out_vld),
      .rd_err      (rd_err)
   );

   assign mem_wr_en = ctl.mem_wr;
   assign mem_rd_en = ctl.mem_rd;
   assign empty_ofs = ofs_q[OFS_W-1:0];
   assign full_ofs  = ofs_q[2*OFS_W-1:OFS_W];

endmodule

// File: rtl/flofs_loader_chk.sv
module flofs_loader_chk #(
   parameter int OFS_W = 19,
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_sel_n,
   input logic             wr_n,
   input logic             rd_n,
   input logic             shift_n,
   input logic             mem_wr_en,
   input logic             mem_rd_en,
   input logic [BUS_W-1:0] bus_out,
   input logic             bus_out_vld,
   input logic             rd_err,
   input logic [OFS_W-1:0] empty_ofs,
   input logic [OFS_W-1:0] full_ofs
);

   assert_mem_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_sel_n |-> (!mem_wr_en && !mem_rd_en));

   assert_vld_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_out_vld |=> !bus_out_vld);

   assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> ($past(!acc_sel_n && !rd_n, 1) && $past(!acc_sel_n && !rd_n, 2)));

   assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_err && bus_out_vld));

   assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_out_vld |-> $stable(bus_out));

   assert_ofs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_sel_n || (wr_n && shift_n)) |-> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

bind flofs_loader flofs_loader_chk #(.OFS_W(LO_W + HI_W), .BUS_W(BUS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_sel_n   (acc_sel_n),
   .wr_n        (wr_n),
   .rd_n        (rd_n),
   .shift_n     (shift_n),
   .mem_wr_en   (mem_wr_en),
   .mem_rd_en   (mem_rd_en),
   .bus_out     (bus_out),
   .bus_out_vld (bus_out_vld),
   .rd_err      (rd_err),
   .empty_ofs   (empty_ofs),
   .full_ofs    (full_ofs)
);

// File: tb/sim_flofs_loader.sv
module sim_flofs_loader;

   localparam int LW = 16;
   localparam int HW = 3;
   localparam int BW = 18;
   localparam int OW = LW + HW;
   localparam int SB = 2 * OW;
   localparam logic [OW-1:0] DE = 19'h12345;
   localparam logic [OW-1:0] DF = 19'h6789A;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0, ser_mode_cfg = 1'b0;
   logic          acc_sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, shift_n = 1'b1;
   logic [BW-1:0] bus_in = '0;
   logic          shift_din = 1'b0;
   logic          mem_wr_en, mem_rd_en, bus_out_vld, rd_err;
   logic [BW-1:0] bus_out;
   logic [OW-1:0] empty_ofs, full_ofs;

   flofs_loader #(.LO_W(LW), .HI_W(HW), .BUS_W(BW), .DEF_EMPTY(DE), .DEF_FULL(DF)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_mode_cfg(ser_mode_cfg), .acc_sel_n(acc_sel_n),
      .wr_n(wr_n), .rd_n(rd_n), .shift_n(shift_n), .bus_in(bus_in), .shift_din(shift_din),
      .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .bus_out(bus_out),
      .bus_out_vld(bus_out_vld), .rd_err(rd_err), .empty_ofs(empty_ofs), .full_ofs(full_ofs));

   // Behavioural reference state
   logic [SB-1:0] m_ofs;
   logic [BW-1:0] m_dout;
   int            m_wp, m_rp, m_sp;
   bit            m_mode, m_prev, m_vld, m_err;

   int    checks = 0, fails = 0;
   string tag = "R1";
   bit    done = 1'b0;

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] part_get(int p);
      case (p)
         0: return BW'(m_ofs[LW-1:0]);
         1: return BW'(m_ofs[OW-1:LW]);
         2: return BW'(m_ofs[OW+LW-1:OW]);
         default: return BW'(m_ofs[SB-1:OW+LW]);
      endcase
   endfunction

   task automatic part_put(int p, logic [BW-1:0] d);
      case (p)
         0: m_ofs[LW-1:0]       = d[LW-1:0];
         1: m_ofs[OW-1:LW]      = d[HW-1:0];
         2: m_ofs[OW+LW-1:OW]   = d[LW-1:0];
         default: m_ofs[SB-1:OW+LW] = d[HW-1:0];
      endcase
   endtask

   task automatic compare();
      chk("empty_ofs", 64'(empty_ofs), 64'(m_ofs[OW-1:0]));
      chk("full_ofs",  64'(full_ofs),  64'(m_ofs[SB-1:OW]));
      chk("bus_out_vld", 64'(bus_out_vld), 64'(m_vld));
      chk("rd_err", 64'(rd_err), 64'(m_err));
      chk("bus_out", 64'(bus_out), 64'(m_dout));
   endtask

   // One clock: drive at the falling edge, step the model, compare at the next falling edge.
   task automatic cyc(bit acc, bit wr, bit rd, bit sh, logic [BW-1:0] d, bit s);
      bit rq, wq, sq;
      acc_sel_n = acc; wr_n = wr; rd_n = rd; shift_n = sh; bus_in = d; shift_din = s;
      #1;
      chk("mem_wr_en", 64'(mem_wr_en), 64'(acc && !wr));
      chk("mem_rd_en", 64'(mem_rd_en), 64'(acc && !rd));
      rq = !acc && !rd;
      wq = !acc && !wr && !m_mode;
      sq = !acc && !sh && m_mode;
      m_vld = 1'b0; m_err = 1'b0;
      if (rq && !m_prev) begin
         m_dout = part_get(m_rp); m_vld = 1'b1; m_rp = (m_rp + 1) % 4;
      end else if (rq) begin
         m_err = 1'b1;
      end
      m_prev = rq;
      if (wq) begin part_put(m_wp, d); m_wp = (m_wp + 1) % 4; end
      if (sq) begin m_ofs[m_sp] = s; m_sp = (m_sp + 1) % SB; end
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0);
   endtask

   task automatic do_reset(bit cfg);
      ser_mode_cfg = cfg;
      acc_sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; shift_n = 1'b1;
      rst_n = 1'b0;
      m_ofs = {DF, DE}; m_dout = '0; m_wp = 0; m_rp = 0; m_sp = 0;
      m_mode = cfg; m_prev = 1'b0; m_vld = 1'b0; m_err = 1'b0;
      repeat (2) @(negedge clk);
      tag = "R1";
      compare();
      rst_n = 1'b1;
      @(negedge clk);
      compare();
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   localparam logic [SB-1:0] SER_PAT = 38'h2A_5C3E_91B7;

   initial begin
      @(negedge clk);
      do_reset(1'b0);

      tag = "R2";
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 18'h3FFFF, 1'b0);
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 18'h3FFFF, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 18'h15555, 1'b0);
      tag = "R11";
      idle(3);

      tag = "R3";
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h3BEEF, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h3FFFD, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h0CAFE, 1'b0);
      idle(1);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h2AAA2, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h01234, 1'b0);

      tag = "R5";
      for (int i = 0; i < 5; i++) begin
         cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
         idle(1);
      end
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 18'h0F0F0, 1'b0);

      tag = "R7";
      idle(1);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
      idle(1);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
      cyc(1'b1, 1'b1, 1'b0, 1'b1, '0, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);

      tag = "R9";
      for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, i[0]);

      tag = "R10";
      ser_mode_cfg = 1'b1;
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b1);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h00777, 1'b0);
      do_reset(1'b1);
      ser_mode_cfg = 1'b0;

      tag = "R8";
      for (int i = 0; i < SB; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, SER_PAT[i]);
      idle(1);
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, '0, ~SER_PAT[i]);

      tag = "R4";
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h3FFFF, 1'b0);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 18'h00000, 1'b0);

      tag = "R6";
      for (int i = 0; i < 4; i++) begin
         cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0);
         idle(1);
      end

      tag = "R11";
      idle(2);

      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL %s watchdog act=running exp=finished", tag);
         report();
         $finish;
      end
   end

endmodule